// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is a slave configuration port on a three-wire serial link made of a serial clock, a serial data line and an active-low select. Up to 64 such ports can share the same wiring. Each port is told apart by a 6-bit address strapped on its `dev_addr` input. While select is low, the port shifts in bytes MSB first on rising serial-clock edges. The first byte of a transfer is a header. Bits 5:0 carry the target address, bit 6 picks the channel side (0 = X, 1 = Y), and bit 7 is reserved and ignored.

When the header address matches the strap, the next three bytes are written in order to that side's control register, input-timeslot register and output-timeslot register. When the address does not match, the rest of the transfer is dropped. Every serial input passes through a synchronizer into the system clock domain. Registers change only once a full byte has been received.

Bit 0 of a side's control register is the interface-off flag. When it is set, the side's PCM output driver is disabled. The other control bits (idle, algorithm reset, bypass, data format, coding law) are passed through unchanged to the PCM side. The controller is a state machine with these states:
- S_IDLE: select high.
- S_ADDR: waiting for the header.
- S_CTRL, S_INSLOT, S_OUTSLOT: payload bytes.
- S_DONE: payload complete, extra bytes ignored.
- S_SKIP: address mismatch, all bytes ignored.

Transitions:
- Any state goes to S_IDLE while select is high.
- S_IDLE goes to S_ADDR when select is low.
- S_ADDR goes to S_CTRL on a matching header and to S_SKIP on a mismatch.
- Each payload state advances on a received byte: S_CTRL to S_INSLOT to S_OUTSLOT to S_DONE.
- S_DONE and S_SKIP hold until select rises.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset both sides hold control 0x01 (interface off), both timeslot registers hold 0x00, and both drive-enable outputs are 0.
- R2: Bits are taken MSB first, one per rising edge of the serial clock, only while select is low.
- R3: The header's bits 5:0 are compared with `dev_addr`; header bit 7 has no effect on matching or on the write.
- R4: On a match, the three following bytes go to control, input timeslot and output timeslot, in that order.
- R5: Header bit 6 = 0 writes the X side, 1 writes the Y side; the other side keeps its values.
- R6: On an address mismatch no register of either side changes for the rest of the transfer.
- R7: Bytes after the third payload byte change nothing until select has gone high.
- R8: Raising select discards any partial byte and returns the port to waiting for a header; bytes already written stay.
- R9: A register keeps its old value until all eight bits of its byte are received.
- R10: A side's drive-enable output is 1 exactly when bit 0 of that side's control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_din | input | 1 | Serial data, MSB first |
| ser_sel_n | input | 1 | Active-low transfer select |
| dev_addr | input | 6 | Strapped device address |
| x_ctrl | output | 8 | X side control register |
| x_in_slot | output | 8 | X side input timeslot |
| x_out_slot | output | 8 | X side output timeslot |
| x_drv_en | output | 1 | X side PCM output enable |
| y_ctrl | output | 8 | Y side control register |
| y_in_slot | output | 8 | Y side input timeslot |
| y_out_slot | output | 8 | Y side output timeslot |
| y_drv_en | output | 1 | Y side PCM output enable |

## Verification
The assertions assume the serial link is slow compared with the system clock. Each serial-clock phase must last longer than the synchronizer depth plus one cycle, so every rising edge is seen exactly once. Select must only change while the serial clock is low, and it must stay low for several system cycles after the last rising edge of a transfer. The bench keeps to these rules by holding each serial phase for four system clocks. It changes data and select only on the low phase and pads eight cycles around select changes. After each completed byte it compares a behavioural model of the registers with the outputs on every clock.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int BYTE_W       = 8;
    localparam int NUM_SIDES    = 2;
    localparam int CTRL_OFF_BIT = 0;
    localparam logic [BYTE_W-1:0] CTRL_RST = 8'h01;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CTRL, S_INSLOT, S_OUTSLOT, S_DONE, S_SKIP
    } port_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] in_slot;
        logic [BYTE_W-1:0] out_slot;
    } side_regs_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d_in;
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
        end
    end

    assign q_out = stg[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter import cfg_port_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              din_s,
    input  logic              sel_n_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_d;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rise;

    assign rise = sclk_s & ~sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            sclk_d   <= sclk_s;
            byte_vld <= 1'b0;
            if (sel_n_s) begin
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (rise) begin
                shreg <= {shreg[BYTE_W-2:0], din_s};
                if (bit_cnt == CNT_W'(BYTE_W-1)) begin
                    bit_cnt  <= '0;
                    byte_vld <= 1'b1;
                    byte_q   <= {shreg[BYTE_W-2:0], din_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    AST_DESEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (bit_cnt == '0 && !byte_vld)); // R8
    AST_ONE_BYTE_PER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> bit_cnt == '0); // R2
endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm import cfg_port_pkg::*; #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n_s,
    input  logic              byte_vld,
    input  logic [ADDR_W-1:0] addr_fld,
    input  logic              side_fld,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic              side_q,
    output logic              wr_ctrl,
    output logic              wr_in,
    output logic              wr_out
);
    port_state_t state, nxt;
    logic take;

    assign take = byte_vld & ~sel_n_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            side_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_ADDR && take) side_q <= side_fld;
        end
    end

    always_comb begin
        nxt = state;
        if (sel_n_s) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:    nxt = S_ADDR;
                S_ADDR:    if (take) nxt = (addr_fld == dev_addr) ? S_CTRL : S_SKIP;
                S_CTRL:    if (take) nxt = S_INSLOT;
                S_INSLOT:  if (take) nxt = S_OUTSLOT;
                S_OUTSLOT: if (take) nxt = S_DONE;
                S_DONE:    nxt = S_DONE;
                S_SKIP:    nxt = S_SKIP;
                default:   nxt = S_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_ctrl = 1'b0;
        wr_in   = 1'b0;
        wr_out  = 1'b0;
        if (take) begin
            case (state)
                S_CTRL:    wr_ctrl = 1'b1;
                S_INSLOT:  wr_in   = 1'b1;
                S_OUTSLOT: wr_out  = 1'b1;
                default:   ;
            endcase
        end
    end

    AST_CTRL_THEN_IN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> state == S_INSLOT); // R4
    AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP && !sel_n_s) |=> state == S_SKIP); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DONE && !sel_n_s) |=> state == S_DONE); // R7
    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> state == S_IDLE); // R8
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank import cfg_port_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_in,
    input  logic              wr_out,
    input  logic [BYTE_W-1:0] wdata,
    output side_regs_t        regs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs.ctrl     <= CTRL_RST;
            regs.in_slot  <= '0;
            regs.out_slot <= '0;
        end else begin
            if (wr_ctrl) regs.ctrl     <= wdata;
            if (wr_in)   regs.in_slot  <= wdata;
            if (wr_out)  regs.out_slot <= wdata;
        end
    end

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl | wr_in | wr_out) |=> $stable(regs)); // R9
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port import cfg_port_pkg::*; #(
    parameter int ADDR_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_sel_n,
    input  logic [ADDR_W-1:0] dev_addr,
    output logic [7:0]        x_ctrl,
    output logic [7:0]        x_in_slot,
    output logic [7:0]        x_out_slot,
    output logic              x_drv_en,
    output logic [7:0]        y_ctrl,
    output logic [7:0]        y_in_slot,
    output logic [7:0]        y_out_slot,
    output logic              y_drv_en
);
    localparam int SIDE_BIT = ADDR_W;

    logic [2:0]        sync_q;
    logic              sel_n_s, sclk_s, din_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;
    logic              side_q, wr_ctrl, wr_in, wr_out;
    side_regs_t        bank_q [NUM_SIDES];

    cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({ser_sel_n, ser_clk, ser_din}),
        .q_out(sync_q)
    );
    assign {sel_n_s, sclk_s, din_s} = sync_q;

    cfg_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .din_s(din_s),
        .sel_n_s(sel_n_s), .byte_vld(byte_vld), .byte_q(byte_q)
    );

    cfg_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_n_s(sel_n_s), .byte_vld(byte_vld),
        .addr_fld(byte_q[ADDR_W-1:0]), .side_fld(byte_q[SIDE_BIT]),
        .dev_addr(dev_addr), .side_q(side_q),
        .wr_ctrl(wr_ctrl), .wr_in(wr_in), .wr_out(wr_out)
    );

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        logic hit;
        assign hit = (int'(side_q) == s);
        cfg_bank u_bank (
            .clk(clk), .rst_n(rst_n),
            .wr_ctrl(wr_ctrl & hit), .wr_in(wr_in & hit), .wr_out(wr_out & hit),
            .wdata(byte_q), .regs(bank_q[s])
        );
    end

    assign x_ctrl     = bank_q[0].ctrl;
    assign x_in_slot  = bank_q[0].in_slot;
    assign x_out_slot = bank_q[0].out_slot;
    assign x_drv_en   = ~bank_q[0].ctrl[CTRL_OFF_BIT];
    assign y_ctrl     = bank_q[1].ctrl;
    assign y_in_slot  = bank_q[1].in_slot;
    assign y_out_slot = bank_q[1].out_slot;
    assign y_drv_en   = ~bank_q[1].ctrl[CTRL_OFF_BIT];

    AST_ONE_SIDE_CHANGES: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(bank_q[0]) || $stable(bank_q[1])) == 1'b0); // R5
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_din = 1'b0, ser_sel_n = 1'b1;
    logic [5:0] dev_addr = 6'h2A;
    logic [7:0] x_ctrl, x_in_slot, x_out_slot, y_ctrl, y_in_slot, y_out_slot;
    logic x_drv_en, y_drv_en;

    cfg_serial_port dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0, last_rise = 0;
    logic [7:0] m_reg [2][3];
    int m_idx = 0;
    int m_side = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && (cyc - last_rise) >= 8) begin
            chk("R4 x_ctrl model", x_ctrl, m_reg[0][0]);
            chk("R4 x_in model", x_in_slot, m_reg[0][1]);
            chk("R4 x_out model", x_out_slot, m_reg[0][2]);
            chk("R5 y_ctrl model", y_ctrl, m_reg[1][0]);
            chk("R5 y_in model", y_in_slot, m_reg[1][1]);
            chk("R5 y_out model", y_out_slot, m_reg[1][2]);
            chk("R10 x_drv model", {7'd0, x_drv_en}, {7'd0, ~m_reg[0][0][0]});
            chk("R10 y_drv model", {7'd0, y_drv_en}, {7'd0, ~m_reg[1][0][0]});
        end
    end

    task automatic model_byte(input logic [7:0] b);
        if (m_idx == 0) begin
            m_side = int'(b[6]);
            m_idx  = (b[5:0] == dev_addr) ? 1 : 4;
        end else if (m_idx <= 3) begin
            m_reg[m_side][m_idx-1] = b;
            m_idx++;
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_range(input logic [7:0] b, input int hi, input int lo, input bit commit);
        for (int i = hi; i >= lo; i--) begin
            ser_din = b[i];
            wait_clk(4);
            ser_clk = 1'b1;
            last_rise = cyc;
            if (i == 0 && commit) model_byte(b);
            wait_clk(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_range(b, 7, 0, 1'b1);
    endtask

    task automatic start_xfer();
        wait_clk(8);
        ser_sel_n = 1'b0;
        m_idx = 0;
        wait_clk(8);
    endtask

    task automatic end_xfer();
        wait_clk(8);
        ser_sel_n = 1'b1;
        wait_clk(10);
    endtask

    always @(posedge clk) begin
        if (cyc == 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_reg[s][0] = 8'h01; m_reg[s][1] = 8'h00; m_reg[s][2] = 8'h00;
        end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(12);
        // R1 reset state
        chk("R1 x_ctrl", x_ctrl, 8'h01);
        chk("R1 y_ctrl", y_ctrl, 8'h01);
        chk("R1 x_in", x_in_slot, 8'h00);
        chk("R1 y_out", y_out_slot, 8'h00);
        chk("R1 drv", {6'd0, x_drv_en, y_drv_en}, 8'h00);

        // R2 R4: X side write, asymmetric values expose bit order
        start_xfer();
        send_byte(8'h2A); send_byte(8'h3C); send_byte(8'h05); send_byte(8'hA0);
        end_xfer();
        chk("R2 x_in MSB first", x_in_slot, 8'h05);
        chk("R4 x_ctrl", x_ctrl, 8'h3C);
        chk("R4 x_out", x_out_slot, 8'hA0);
        chk("R10 x_drv_en on", {7'd0, x_drv_en}, 8'h01);
        chk("R5 y untouched", y_ctrl, 8'h01);

        // R3 R5: Y side with reserved bit 7 set
        start_xfer();
        send_byte(8'hEA); send_byte(8'h81); send_byte(8'h1F); send_byte(8'h20);
        end_xfer();
        chk("R3 y_ctrl bit7 ignored", y_ctrl, 8'h81);
        chk("R5 y_in", y_in_slot, 8'h1F);
        chk("R5 x kept", x_ctrl, 8'h3C);
        chk("R10 y_drv_en off", {7'd0, y_drv_en}, 8'h00);

        // R6: address mismatch
        start_xfer();
        send_byte(8'h2B); send_byte(8'h77); send_byte(8'h66); send_byte(8'h55);
        end_xfer();
        chk("R6 x_ctrl", x_ctrl, 8'h3C);
        chk("R6 x_in", x_in_slot, 8'h05);
        chk("R6 y_ctrl", y_ctrl, 8'h81);

        // R7: extra bytes after payload
        start_xfer();
        send_byte(8'h2A); send_byte(8'h10); send_byte(8'h11); send_byte(8'h12);
        send_byte(8'h99); send_byte(8'h98); send_byte(8'h97);
        end_xfer();
        chk("R7 x_ctrl", x_ctrl, 8'h10);
        chk("R7 x_in", x_in_slot, 8'h11);
        chk("R7 x_out", x_out_slot, 8'h12);

        // R9: half a byte does not update
        start_xfer();
        send_byte(8'h6A);
        send_range(8'hC3, 7, 4, 1'b0);
        wait_clk(10);
        chk("R9 y_ctrl half byte", y_ctrl, 8'h81);
        send_range(8'hC3, 3, 0, 1'b1);
        wait_clk(10);
        chk("R9 y_ctrl full byte", y_ctrl, 8'hC3);
        // R8: abort mid-byte, written bytes stay
        send_range(8'hFF, 7, 3, 1'b0);
        end_xfer();
        chk("R8 y_ctrl kept", y_ctrl, 8'hC3);
        chk("R8 y_in untouched", y_in_slot, 8'h1F);
        start_xfer();
        send_byte(8'h6A); send_byte(8'h44); send_byte(8'h33); send_byte(8'h22);
        end_xfer();
        chk("R8 fresh y_ctrl", y_ctrl, 8'h44);
        chk("R8 fresh y_in", y_in_slot, 8'h33);
        chk("R8 fresh y_out", y_out_slot, 8'h22);

        // R3: another strap value
        dev_addr = 6'h05;
        wait_clk(4);
        start_xfer();
        send_byte(8'h85); send_byte(8'h07); send_byte(8'h08); send_byte(8'h09);
        end_xfer();
        chk("R3 new strap x_ctrl", x_ctrl, 8'h07);
        chk("R10 x_drv_en off", {7'd0, x_drv_en}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule